// File: doc/BRIEF.md
# Peripheral Request to Channel Router

This block steers peripheral DMA request lines onto DMA channel request inputs. Each request line owns one map register. The register holds an enable flag and the number of the channel that the line should drive. Every channel's request output is the OR of all request lines that are enabled and point at that channel. Software sets up the routing through a small register port with valid, write, address and data signals.

The map registers sit in two address windows of 64 slots each. The lower window serves request lines 0 to 63 and the upper window serves lines 64 to 127. Channel arbitration, data movement and channel control belong to other blocks.

A state machine with two states handles register reads. `ACC_IDLE` waits for an access. An accepted read takes the transition idle-to-respond and moves to `ACC_RESP`, which presents the read data for one cycle. From `ACC_RESP`, a further read takes the respond-to-respond transition, and no read takes the respond-to-idle transition. Writes are accepted in either state.

Top module: `req_channel_router`

## Requirements
- R1: After reset, every map entry is disabled, `chan_req` is all zero and `reg_rvalid` is low.
- R2: For request line n below 64, the map register is at byte address 0x100 + 4*n.
- R3: For request line n from 64 to 127, the map register is at byte address 0x1100 + 4*(n-64). These registers are separate from the lower window's registers.
- R4: A write stores data bit 7 as the enable flag and data bits 4:0 as the channel number, and discards all other bits. A read returns the enable flag in bit 7 and the channel number in bits 4:0, with every other bit zero.
- R5: Suppose a request line is high, its entry is enabled and the entry names channel c. Then `chan_req[c]` is high on the clock edge after the request is sampled, and the line drives no other channel.
- R6: When several enabled entries name the same channel, that channel's request is the OR of their request lines.
- R7: A line whose entry has the enable flag clear drives no channel. Writing zero to an entry removes its mapping.
- R8: The block ignores a write when its address is unaligned (bits 1:0 not zero), lies outside both windows, or names a line at or above NUM_REQ. A read at such an address returns zero.
- R9: `reg_rvalid` is high in the cycle after each accepted read and low otherwise. Back-to-back reads keep it high on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Byte address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid while reg_rvalid is high |
| reg_rvalid | output | 1 | Read response strobe |
| periph_req | input | NUM_REQ | Peripheral request lines |
| chan_req | output | NUM_CHAN | Routed request for each channel |

## Verification
The block has three kinds of result, and each has a fixed delay:
- A map write takes effect at the edge on which it is sampled.
- A read's data and `reg_rvalid` appear in the cycle after the read is sampled and leave one cycle later.
- A change on `periph_req` reaches `chan_req` one edge after it is sampled.

The bench drives inputs on the falling edge and samples outputs on the next falling edge. Every sample therefore lands in the cycle where the result is due, and a second sample confirms that `reg_rvalid` falls again. Expected routing and read values come from a model of the map, which the bench updates by its own address decoding of each write.

// File: rtl/rcr_pkg.sv
package rcr_pkg;

    localparam int MAP_CHAN_W    = 5;
    localparam int MAP_VALID_BIT = 7;

    typedef struct packed {
        logic                  valid;
        logic [MAP_CHAN_W-1:0] chan;
    } map_entry_t;

    typedef enum logic [0:0] {
        ACC_IDLE,
        ACC_RESP
    } acc_state_t;

endpackage

// File: rtl/rcr_addr_decode.sv
module rcr_addr_decode #(
    parameter int          ADDR_W    = 16,
    parameter int          NUM_REQ   = 128,
    parameter int          IDX_W     = 7,
    parameter logic [31:0] LO_BASE   = 32'h0000_0100,
    parameter logic [31:0] HI_BASE   = 32'h0000_1100,
    parameter int          WIN_SLOTS = 64
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [IDX_W-1:0]  idx
);

    localparam logic [31:0] WIN_BYTES = 32'(WIN_SLOTS * 4);

    logic [31:0] a32;
    logic [31:0] lo_off;
    logic [31:0] hi_off;
    logic [31:0] slot;
    logic [31:0] req_num;
    logic        in_lo;
    logic        in_hi;
    logic        aligned;

    always_comb begin
        a32     = 32'(addr);
        lo_off  = a32 - LO_BASE;
        hi_off  = a32 - HI_BASE;
        aligned = (a32[1:0] == 2'b00);
        in_lo   = (a32 >= LO_BASE) && (lo_off < WIN_BYTES);
        in_hi   = (a32 >= HI_BASE) && (hi_off < WIN_BYTES);
        slot    = in_lo ? (lo_off >> 2) : (hi_off >> 2);
        req_num = in_lo ? slot : (slot + 32'(WIN_SLOTS));
        hit     = aligned && (in_lo || in_hi) && (req_num < 32'(NUM_REQ));
        idx     = req_num[IDX_W-1:0];
    end

endmodule

// File: rtl/rcr_map_regs.sv
module rcr_map_regs
    import rcr_pkg::*;
#(
    parameter int NUM_REQ = 128,
    parameter int IDX_W   = 7
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [IDX_W-1:0]           wr_idx,
    input  map_entry_t                 wr_entry,
    output map_entry_t [NUM_REQ-1:0]   map_q
);

    for (genvar r = 0; r < NUM_REQ; r++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                map_q[r] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(r))) begin
                map_q[r] <= wr_entry;
            end
        end
    end

endmodule

// File: rtl/rcr_route.sv
module rcr_route
    import rcr_pkg::*;
#(
    parameter int NUM_REQ  = 128,
    parameter int NUM_CHAN = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  map_entry_t [NUM_REQ-1:0] map_q,
    input  logic [NUM_REQ-1:0]       req_in,
    output logic [NUM_CHAN-1:0]      chan_req_q
);

    logic [NUM_CHAN-1:0] chan_next;

    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
        logic [NUM_REQ-1:0] sel;
        always_comb begin
            for (int r = 0; r < NUM_REQ; r++) begin
                sel[r] = req_in[r] && map_q[r].valid &&
                         (map_q[r].chan == MAP_CHAN_W'(c));
            end
        end
        assign chan_next[c] = |sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chan_req_q <= '0;
        end else begin
            chan_req_q <= chan_next;
        end
    end

endmodule

// File: rtl/rcr_access_fsm.sv
module rcr_access_fsm
    import rcr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic              rd_hit,
    input  map_entry_t        rd_entry,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data
);

    acc_state_t state_q;
    acc_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACC_IDLE: if (rd_req) state_d = ACC_RESP;
            ACC_RESP: state_d = rd_req ? ACC_RESP : ACC_IDLE;
            default:  state_d = ACC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ACC_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_data <= '0;
        end else if (rd_req) begin
            rsp_data <= rd_hit ? DATA_W'({rd_entry.valid, 2'b00, rd_entry.chan}) : '0;
        end
    end

    assign rsp_valid = (state_q == ACC_RESP);

endmodule

// File: rtl/req_channel_router.sv
module req_channel_router
    import rcr_pkg::*;
#(
    parameter int NUM_REQ  = 128,
    parameter int NUM_CHAN = 32,
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_valid,
    input  logic                reg_write,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic                reg_rvalid,
    input  logic [NUM_REQ-1:0]  periph_req,
    output logic [NUM_CHAN-1:0] chan_req
);

    localparam int IDX_W = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1;

    logic                      addr_hit;
    logic [IDX_W-1:0]          addr_idx;
    logic                      wr_en;
    logic                      rd_req;
    map_entry_t                wr_entry;
    map_entry_t                rd_entry;
    map_entry_t [NUM_REQ-1:0]  map_q;
    logic [DATA_W-1:0]         wdata_unused;

    assign wdata_unused = reg_wdata;

    rcr_addr_decode #(
        .ADDR_W  (ADDR_W),
        .NUM_REQ (NUM_REQ),
        .IDX_W   (IDX_W)
    ) i_decode (
        .addr (reg_addr),
        .hit  (addr_hit),
        .idx  (addr_idx)
    );

    assign wr_en          = reg_valid && reg_write && addr_hit;
    assign rd_req         = reg_valid && !reg_write;
    assign wr_entry.valid = reg_wdata[MAP_VALID_BIT];
    assign wr_entry.chan  = reg_wdata[MAP_CHAN_W-1:0];
    assign rd_entry       = addr_hit ? map_q[addr_idx] : '0;

    rcr_map_regs #(
        .NUM_REQ (NUM_REQ),
        .IDX_W   (IDX_W)
    ) i_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (addr_idx),
        .wr_entry (wr_entry),
        .map_q    (map_q)
    );

    rcr_route #(
        .NUM_REQ  (NUM_REQ),
        .NUM_CHAN (NUM_CHAN)
    ) i_route (
        .clk        (clk),
        .rst_n      (rst_n),
        .map_q      (map_q),
        .req_in     (periph_req),
        .chan_req_q (chan_req)
    );

    rcr_access_fsm #(
        .DATA_W (DATA_W)
    ) i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_req    (rd_req),
        .rd_hit    (addr_hit),
        .rd_entry  (rd_entry),
        .rsp_valid (reg_rvalid),
        .rsp_data  (reg_rdata)
    );

endmodule

// File: rtl/rcr_checker.sv
module rcr_checker #(
    parameter int NUM_REQ  = 128,
    parameter int NUM_CHAN = 32,
    parameter int DATA_W   = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                reg_valid,
    input logic                reg_write,
    input logic [DATA_W-1:0]   reg_rdata,
    input logic                reg_rvalid,
    input logic [NUM_REQ-1:0]  periph_req,
    input logic [NUM_CHAN-1:0] chan_req
);

    a_r9_resp_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_valid && !reg_write) |=> reg_rvalid);

    a_r9_resp_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rvalid |-> $past(reg_valid && !reg_write));

    a_r4_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rvalid |-> (reg_rdata[DATA_W-1:8] == '0 && reg_rdata[6:5] == 2'b00));

    a_r5_no_fanout: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(chan_req) <= $countones($past(periph_req)));

    a_r7_quiet_without_requests: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(periph_req) == '0) |-> (chan_req == '0));

endmodule

bind req_channel_router rcr_checker #(
    .NUM_REQ  (NUM_REQ),
    .NUM_CHAN (NUM_CHAN),
    .DATA_W   (DATA_W)
) i_rcr_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_valid  (reg_valid),
    .reg_write  (reg_write),
    .reg_rdata  (reg_rdata),
    .reg_rvalid (reg_rvalid),
    .periph_req (periph_req),
    .chan_req   (chan_req)
);

// File: tb/test_req_channel_router.sv
module test_req_channel_router;

    localparam int NUM_REQ  = 128;
    localparam int NUM_CHAN = 32;
    localparam int ADDR_W   = 16;
    localparam int DATA_W   = 32;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                reg_valid = 1'b0;
    logic                reg_write = 1'b0;
    logic [ADDR_W-1:0]   reg_addr = '0;
    logic [DATA_W-1:0]   reg_wdata = '0;
    logic [DATA_W-1:0]   reg_rdata;
    logic                reg_rvalid;
    logic [NUM_REQ-1:0]  periph_req = '0;
    logic [NUM_CHAN-1:0] chan_req;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    bit m_valid [NUM_REQ];
    int m_chan  [NUM_REQ];

    always #10 clk = ~clk;

    req_channel_router #(
        .NUM_REQ  (NUM_REQ),
        .NUM_CHAN (NUM_CHAN),
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W)
    ) i_req_channel_router (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_valid  (reg_valid),
        .reg_write  (reg_write),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .reg_rvalid (reg_rvalid),
        .periph_req (periph_req),
        .chan_req   (chan_req)
    );

    task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int model_index(input int a);
        int n;
        if (a[1:0] != 2'b00) return -1;
        if (a >= 32'h100 && a < 32'h200) n = (a - 32'h100) / 4;
        else if (a >= 32'h1100 && a < 32'h1200) n = 64 + (a - 32'h1100) / 4;
        else return -1;
        if (n >= NUM_REQ) return -1;
        return n;
    endfunction

    function automatic logic [NUM_CHAN-1:0] model_route(input logic [NUM_REQ-1:0] req);
        logic [NUM_CHAN-1:0] r = '0;
        for (int i = 0; i < NUM_REQ; i++) begin
            if (req[i] && m_valid[i] && m_chan[i] < NUM_CHAN) r[m_chan[i]] = 1'b1;
        end
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] model_read(input int a);
        int n = model_index(a);
        if (n < 0) return '0;
        return DATA_W'({m_valid[n], 2'b00, 5'(m_chan[n])});
    endfunction

    task automatic do_write(input int a, input logic [DATA_W-1:0] d);
        int n;
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b1; reg_addr = ADDR_W'(a); reg_wdata = d;
        @(negedge clk);
        reg_valid = 1'b0; reg_write = 1'b0;
        n = model_index(a);
        if (n >= 0) begin
            m_valid[n] = d[7];
            m_chan[n]  = int'(d[4:0]);
        end
    endtask

    task automatic expect_read(input int a, input string tag);
        logic [DATA_W-1:0] exp = model_read(a);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b0; reg_addr = ADDR_W'(a);
        @(negedge clk);
        reg_valid = 1'b0;
        check(reg_rvalid === 1'b1, "R9 rvalid after read", 128'(reg_rvalid), 128'(1));
        check(reg_rdata === exp, tag, 128'(reg_rdata), 128'(exp));
        @(negedge clk);
        check(reg_rvalid === 1'b0, "R9 rvalid drops", 128'(reg_rvalid), 128'(0));
    endtask

    task automatic drive_req(input logic [NUM_REQ-1:0] v, input string tag);
        logic [NUM_CHAN-1:0] exp;
        @(negedge clk);
        periph_req = v;
        exp = model_route(v);
        @(negedge clk);
        check(chan_req === exp, tag, 128'(chan_req), 128'(exp));
    endtask

    task automatic t_reset;
        check(chan_req === '0, "R1 chan_req in reset", 128'(chan_req), 128'(0));
        check(reg_rvalid === 1'b0, "R1 rvalid in reset", 128'(reg_rvalid), 128'(0));
        @(negedge clk);
        rst_n = 1'b1;
        expect_read(32'h100, "R1 entry 0 cleared");
        expect_read(32'h11FC, "R1 entry 127 cleared");
        drive_req('1, "R1 no routing after reset");
        drive_req('0, "R1 idle");
    endtask

    task automatic t_low_window;
        do_write(32'h100 + 4 * 5, 32'h0000_0083);
        expect_read(32'h100 + 4 * 5, "R2 line 5 readback");
        do_write(32'h100 + 4 * 63, 32'hFFFF_FFE9);
        expect_read(32'h100 + 4 * 63, "R4 reserved bits dropped");
    endtask

    task automatic t_high_window;
        do_write(32'h1100 + 4 * (100 - 64), 32'h0000_009F);
        expect_read(32'h1100 + 4 * 36, "R3 line 100 readback");
        expect_read(32'h100 + 4 * 36, "R3 line 36 untouched");
    endtask

    task automatic t_route;
        logic [NUM_REQ-1:0] v;
        v = '0; v[5] = 1'b1;
        drive_req(v, "R5 line 5 to channel 3");
        v = '0; v[100] = 1'b1;
        drive_req(v, "R5 line 100 to channel 31");
        v = '0; v[63] = 1'b1;
        drive_req(v, "R5 line 63 to channel 9");
        drive_req('0, "R5 release");
    endtask

    task automatic t_or;
        logic [NUM_REQ-1:0] v;
        do_write(32'h100 + 4 * 10, 32'h87);
        do_write(32'h1100 + 4 * 6, 32'h87);
        v = '0; v[10] = 1'b1;
        drive_req(v, "R6 first source");
        v = '0; v[70] = 1'b1;
        drive_req(v, "R6 second source");
        v[10] = 1'b1;
        drive_req(v, "R6 both sources");
        drive_req('0, "R6 none");
    endtask

    task automatic t_disable;
        logic [NUM_REQ-1:0] v;
        do_write(32'h100 + 4 * 20, 32'h04);
        v = '0; v[20] = 1'b1;
        drive_req(v, "R7 disabled entry");
        do_write(32'h100 + 4 * 5, 32'h0);
        v = '0; v[5] = 1'b1;
        drive_req(v, "R7 entry cleared by zero");
        expect_read(32'h100 + 4 * 5, "R7 cleared readback");
    endtask

    task automatic t_ignored;
        do_write(32'h0200, 32'h81);
        do_write(32'h1200, 32'h81);
        do_write(32'h00FC, 32'h81);
        do_write(32'h10FC, 32'h81);
        do_write(32'h0105, 32'h8C);
        expect_read(32'h0104, "R8 unaligned write ignored");
        expect_read(32'h0200, "R8 read outside windows");
        drive_req('1, "R8 routing unchanged by stray writes");
        drive_req('0, "R8 idle");
    endtask

    task automatic t_back_to_back;
        logic [DATA_W-1:0] e1;
        logic [DATA_W-1:0] e2;
        e1 = model_read(32'h100 + 4 * 10);
        e2 = model_read(32'h1100 + 4 * 36);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b0; reg_addr = ADDR_W'(32'h100 + 4 * 10);
        @(negedge clk);
        reg_addr = ADDR_W'(32'h1100 + 4 * 36);
        check(reg_rvalid === 1'b1, "R9 first of pair", 128'(reg_rvalid), 128'(1));
        check(reg_rdata === e1, "R9 first data", 128'(reg_rdata), 128'(e1));
        @(negedge clk);
        reg_valid = 1'b0;
        check(reg_rvalid === 1'b1, "R9 second of pair", 128'(reg_rvalid), 128'(1));
        check(reg_rdata === e2, "R9 second data", 128'(reg_rdata), 128'(e2));
        @(negedge clk);
        check(reg_rvalid === 1'b0, "R9 after pair", 128'(reg_rvalid), 128'(0));
    endtask

    initial begin
        for (int i = 0; i < NUM_REQ; i++) begin
            m_valid[i] = 1'b0;
            m_chan[i]  = 0;
        end
        repeat (3) @(negedge clk);
        t_reset;
        t_low_window;
        t_high_window;
        t_route;
        t_or;
        t_disable;
        t_ignored;
        t_back_to_back;
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule